// File: doc/BRIEF.md
# Posted-Write Up-Counting Timer

A 32-bit general-purpose timer driven over a small word-addressed register bus. The counter counts up by one on each clock where the tick-enable input is high and the run bit is set. When it passes the all-ones value it raises an overflow flag. It then either restarts from a software-held reload value or, in one-shot use, drops to zero and stops itself. A compare register can also flag the cycle where the counter equals it. Any raised flag whose enable bit is set drives a level interrupt. A second enable set drives a separate wake output.

Writes to the timing registers (control, counter, reload, trigger and compare) are posted. Each one parks in a staging slot, shows a pending bit for a fixed three-cycle settle window, and only then takes effect. Software polls the pending register before it relies on the new value. A common use is to write the two's-complement negative of a tick count into the counter, which schedules an overflow that many ticks later. Writing the trigger register copies the reload value into the counter.

Top module: `posted_up_timer`

## Requirements
- R1: After reset the counter, control, reload, compare, flag, enable and pending registers read zero, irq and wake are low, status (0x14) bit 0 reads 1, and the identification register (0x00) reads {24'h0, major nibble in 7:4, minor nibble in 3:0}, which is 0x13 at default parameters.
- R2: Registers sit at these byte offsets: identification 0x00, configuration 0x10, status 0x14, flag 0x18, irq enable 0x1C, wake enable 0x20, control 0x24, counter 0x28, reload 0x2C, trigger 0x30, pending 0x34, compare 0x38, capture 0x3C. In the flag and both enable registers, bit 0 is compare, bit 1 is overflow and bit 2 is capture; capture never sets and the capture register reads 0.
- R3: A write to control, counter, reload, trigger or compare sets pending bit 0, 1, 2, 3 or 4 respectively for exactly 3 clock cycles. The new value takes effect in the edge that clears that bit. A second write while the bit is set replaces the staged value and restarts the window.
- R4: With control bit 0 set, the counter rises by one on every clock with tick_en high. With bit 0 clear, it holds. Control bits 5:2 are stored and read back but do not change the count rate.
- R5: A step from 0xFFFFFFFF sets flag bit 1. If control bit 1 is set, the counter continues from the reload value. If it is clear, the counter becomes 0 and control bit 0 clears. A counter value of −N therefore overflows on the N-th step.
- R6: When a trigger write takes effect, the counter is loaded with the reload register value.
- R7: With control bit 6 set, flag bit 0 sets at the edge that ends a cycle in which the counter equals the compare register.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear.
- R9: irq is high while any flag bit and its irq-enable bit are both set, and stays high until software clears the flag or the enable. wake behaves the same way using the wake-enable register.
- R10: Writing configuration bit 1 makes status bit 0 read 0 for one cycle. At the next edge every register returns to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable, one step per clock while high |
| bus_wr | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | Level wake request |

## Verification
The counting path is exercised with three start conditions. The first is a negative preload with auto-reload, where the number of cycles to the interrupt separates a correct settle window and tick count from an off-by-one in either. The second is a one-shot preload, which shows whether the run bit clears on wrap. The third is a preload just below the compare value, which shows whether the compare flag fires on equality rather than one step late. The register table walks each posted register through its pending window and confirms that the old value persists until the window ends. Separate sequences cover override, trigger, masking, write-one-to-clear and soft reset, and each of these changes a different register's observable value.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  localparam int ADDR_W = 8;
  localparam int FLAG_W = 3;
  localparam int CTRL_W = 7;
  localparam int CFG_W  = 10;
  localparam int NSLOT  = 5;

  localparam logic [ADDR_W-1:0] OFS_ID    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CFG   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_FLAG  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_WEN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_CMP   = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_CAPT  = 8'h3C;

  // slot index equals pending bit position
  localparam int SL_CTRL = 0;
  localparam int SL_CNT  = 1;
  localparam int SL_LOAD = 2;
  localparam int SL_TRIG = 3;
  localparam int SL_CMP  = 4;

  localparam logic [ADDR_W-1:0] SLOT_OFS [NSLOT] =
    '{OFS_CTRL, OFS_CNT, OFS_LOAD, OFS_TRIG, OFS_CMP};

  // control bits
  localparam int CB_RUN = 0;
  localparam int CB_AR  = 1;
  localparam int CB_CMP = 6;

  // flag bits
  localparam int FB_MAT = 0;
  localparam int FB_OVF = 1;
  localparam int FB_CAP = 2;

  // configuration bit requesting soft reset
  localparam int CFG_SRST = 1;
endpackage

// File: rtl/gpt_post_slot.sv
module gpt_post_slot #(
  parameter int DW  = 32,
  parameter int DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          pend,
  output logic          apply,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(DLY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] data_q;
  logic          data_en;

  always_comb begin
    cnt_d   = cnt_q;
    data_en = 1'b0;
    if (srst) begin
      cnt_d = '0;
    end else if (wr_en) begin
      cnt_d   = CW'(DLY);
      data_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (data_en) data_q <= wdata;
    end
  end

  assign pend  = (cnt_q != '0);
  assign apply = (cnt_q == CW'(1)) && !wr_en && !srst;
  assign data  = data_q;
endmodule

// File: rtl/gpt_count_core.sv
module gpt_count_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          tick_en,
  input  logic          run,
  input  logic          auto_rl,
  input  logic          cmp_en,
  input  logic [DW-1:0] ld_val,
  input  logic [DW-1:0] cmp_val,
  input  logic          set_cnt,
  input  logic [DW-1:0] set_val,
  input  logic          trig,
  output logic [DW-1:0] cnt,
  output logic          ovf_evt,
  output logic          mat_evt,
  output logic          oneshot_end
);
  logic [DW-1:0] cnt_q, cnt_d;
  logic          at_max, step;

  always_comb begin
    at_max  = &cnt_q;
    step    = run && tick_en;
    ovf_evt = step && at_max && !set_cnt && !trig && !srst;
    cnt_d   = cnt_q;
    if (srst)         cnt_d = '0;
    else if (set_cnt) cnt_d = set_val;
    else if (trig)    cnt_d = ld_val;
    else if (step)    cnt_d = at_max ? (auto_rl ? ld_val : '0) : cnt_q + DW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt         = cnt_q;
  assign oneshot_end = ovf_evt && !auto_rl;
  assign mat_evt     = cmp_en && (cnt_q == cmp_val);
endmodule

// File: rtl/gpt_irq_unit.sv
module gpt_irq_unit #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic [FW-1:0] set_vec,
  input  logic          clr_we,
  input  logic          ien_we,
  input  logic          wen_we,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] ien,
  output logic [FW-1:0] wen,
  output logic          irq,
  output logic          wake
);
  logic [FW-1:0] flg_q, flg_d, ien_q, ien_d, wen_q, wen_d;

  always_comb begin
    flg_d = flg_q;
    ien_d = ien_q;
    wen_d = wen_q;
    if (srst) begin
      flg_d = '0;
      ien_d = '0;
      wen_d = '0;
    end else begin
      if (clr_we) flg_d = flg_q & ~wdata;
      flg_d = flg_d | set_vec;
      if (ien_we) ien_d = wdata;
      if (wen_we) wen_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
      ien_q <= '0;
      wen_q <= '0;
    end else begin
      flg_q <= flg_d;
      ien_q <= ien_d;
      wen_q <= wen_d;
    end
  end

  assign flags = flg_q;
  assign ien   = ien_q;
  assign wen   = wen_q;
  assign irq   = |(flg_q & ien_q);
  assign wake  = |(flg_q & wen_q);
endmodule

// File: rtl/posted_up_timer.sv
module posted_up_timer
  import gpt_pkg::*;
#(
  parameter int DW        = 32,
  parameter int SYNC_DLY  = 3,
  parameter int REV_MAJOR = 1,
  parameter int REV_MINOR = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq,
  output logic              wake
);
  localparam logic [7:0] REV_BYTE = {4'(REV_MAJOR), 4'(REV_MINOR)};

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  // soft reset
  logic srst_q, srst_req, cfg_we;
  logic [CFG_W-1:0] cfg_q, cfg_d;
  assign cfg_we   = bus_wr && (bus_addr == OFS_CFG) && !srst_q;
  assign srst_req = cfg_we && bus_wdata[CFG_SRST];

  always_comb begin
    cfg_d = cfg_q;
    if (srst_q) cfg_d = '0;
    else if (cfg_we) begin
      cfg_d = bus_wdata[CFG_W-1:0];
      cfg_d[CFG_SRST] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      srst_q <= 1'b0;
      cfg_q  <= '0;
    end else begin
      srst_q <= srst_req;
      cfg_q  <= cfg_d;
    end
  end

  // posted write slots
  logic [NSLOT-1:0]  pend, appl;
  logic [CTRL_W-1:0] ctrl_stage;
  logic [DW-1:0]     wide_data [1:NSLOT-1];

  gpt_post_slot #(.DW(CTRL_W), .DLY(SYNC_DLY)) u_slot_ctrl (
    .clk(clk), .rst_n(rst_n_i), .srst(srst_q),
    .wr_en(bus_wr && (bus_addr == SLOT_OFS[SL_CTRL]) && !srst_q),
    .wdata(bus_wdata[CTRL_W-1:0]),
    .pend(pend[SL_CTRL]), .apply(appl[SL_CTRL]), .data(ctrl_stage)
  );

  for (genvar i = 1; i < NSLOT; i++) begin : g_slot
    gpt_post_slot #(.DW(DW), .DLY(SYNC_DLY)) u_slot (
      .clk(clk), .rst_n(rst_n_i), .srst(srst_q),
      .wr_en(bus_wr && (bus_addr == SLOT_OFS[i]) && !srst_q),
      .wdata(bus_wdata),
      .pend(pend[i]), .apply(appl[i]), .data(wide_data[i])
    );
  end

  // applied register values
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     load_q, load_d, trig_q, trig_d, cmp_q, cmp_d;
  logic              oneshot_end;

  always_comb begin
    ctrl_d = ctrl_q;
    load_d = load_q;
    trig_d = trig_q;
    cmp_d  = cmp_q;
    if (srst_q) begin
      ctrl_d = '0;
      load_d = '0;
      trig_d = '0;
      cmp_d  = '0;
    end else begin
      if (appl[SL_CTRL])    ctrl_d = ctrl_stage;
      else if (oneshot_end) ctrl_d[CB_RUN] = 1'b0;
      if (appl[SL_LOAD]) load_d = wide_data[SL_LOAD];
      if (appl[SL_TRIG]) trig_d = wide_data[SL_TRIG];
      if (appl[SL_CMP])  cmp_d  = wide_data[SL_CMP];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
      cmp_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      load_q <= load_d;
      trig_q <= trig_d;
      cmp_q  <= cmp_d;
    end
  end

  // counter
  logic [DW-1:0] cnt;
  logic          ovf_evt, mat_evt;

  gpt_count_core #(.DW(DW)) u_core (
    .clk(clk), .rst_n(rst_n_i), .srst(srst_q), .tick_en(tick_en),
    .run(ctrl_q[CB_RUN]), .auto_rl(ctrl_q[CB_AR]), .cmp_en(ctrl_q[CB_CMP]),
    .ld_val(load_q), .cmp_val(cmp_q),
    .set_cnt(appl[SL_CNT]), .set_val(wide_data[SL_CNT]), .trig(appl[SL_TRIG]),
    .cnt(cnt), .ovf_evt(ovf_evt), .mat_evt(mat_evt), .oneshot_end(oneshot_end)
  );

  // flags and interrupt
  logic [FLAG_W-1:0] flags, ien, wen, set_vec;
  always_comb begin
    set_vec         = '0;
    set_vec[FB_MAT] = mat_evt;
    set_vec[FB_OVF] = ovf_evt;
    set_vec[FB_CAP] = 1'b0;
  end

  gpt_irq_unit #(.FW(FLAG_W)) u_irq (
    .clk(clk), .rst_n(rst_n_i), .srst(srst_q), .set_vec(set_vec),
    .clr_we(bus_wr && (bus_addr == OFS_FLAG) && !srst_q),
    .ien_we(bus_wr && (bus_addr == OFS_IEN) && !srst_q),
    .wen_we(bus_wr && (bus_addr == OFS_WEN) && !srst_q),
    .wdata(bus_wdata[FLAG_W-1:0]),
    .flags(flags), .ien(ien), .wen(wen), .irq(irq), .wake(wake)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_ID:   bus_rdata[7:0]        = REV_BYTE;
      OFS_CFG:  bus_rdata[CFG_W-1:0]  = cfg_q;
      OFS_STAT: bus_rdata[0]          = !srst_q;
      OFS_FLAG: bus_rdata[FLAG_W-1:0] = flags;
      OFS_IEN:  bus_rdata[FLAG_W-1:0] = ien;
      OFS_WEN:  bus_rdata[FLAG_W-1:0] = wen;
      OFS_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      OFS_CNT:  bus_rdata             = cnt;
      OFS_LOAD: bus_rdata             = load_q;
      OFS_TRIG: bus_rdata             = trig_q;
      OFS_PEND: bus_rdata[NSLOT-1:0]  = pend;
      OFS_CMP:  bus_rdata             = cmp_q;
      default:  bus_rdata             = '0;
    endcase
  end
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker
  import gpt_pkg::*;
#(
  parameter int DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              srst,
  input logic              tick_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [NSLOT-1:0]  pend,
  input logic [FLAG_W-1:0] flags,
  input logic              irq,
  input logic              run,
  input logic              set_cnt,
  input logic              trig,
  input logic              ovf_evt,
  input logic [DW-1:0]     cnt
);
  logic side_wr;
  assign side_wr = bus_wr && ((bus_addr == OFS_CFG) || (bus_addr == OFS_FLAG) ||
                              (bus_addr == OFS_IEN));

  // R3: a raised pending bit stays up in the following cycle
  a_r3_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pend[SL_CNT]) && !srst && !side_wr) |=> pend[SL_CNT]);

  // R4: a stopped counter with nothing applied holds its value
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !set_cnt && !trig && !srst) |=> $stable(cnt));

  // R4: a running counter below all-ones steps by one
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick_en && !set_cnt && !trig && !srst && (cnt != '1))
    |=> (cnt == $past(cnt) + DW'(1)));

  // R5: a wrap raises the overflow flag
  a_r5_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !srst) |=> flags[FB_OVF]);

  // R8: write-one clears overflow when no new event coincides
  a_r8_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_FLAG) && bus_wdata[FB_OVF] && !ovf_evt && !srst)
    |=> !flags[FB_OVF]);

  // R9: interrupt level holds until software touches flags or enables
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !srst && !side_wr) |=> irq);
endmodule

bind posted_up_timer gpt_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .srst(srst_q), .tick_en(tick_en),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pend(pend), .flags(flags), .irq(irq), .run(ctrl_q[gpt_pkg::CB_RUN]),
  .set_cnt(appl[gpt_pkg::SL_CNT]), .trig(appl[gpt_pkg::SL_TRIG]),
  .ovf_evt(ovf_evt), .cnt(cnt)
);

// File: tb/tb_posted_up_timer.sv
module tb_posted_up_timer;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n, tick_en, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq, wake;
  int          n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  posted_up_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wake(wake)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h1C, 32'h7},        '{1'b1, 8'h1C, 32'h7},
    '{1'b0, 8'h20, 32'h5},        '{1'b1, 8'h20, 32'h5},
    '{1'b1, 8'h18, 32'h0},        '{1'b0, 8'h38, 32'h1234},
    '{1'b1, 8'h34, 32'h10},       '{1'b1, 8'h34, 32'h10},
    '{1'b1, 8'h34, 32'h10},       '{1'b1, 8'h34, 32'h0},
    '{1'b1, 8'h38, 32'h1234},     '{1'b0, 8'h2C, 32'hA5A50000},
    '{1'b1, 8'h34, 32'h4},        '{1'b1, 8'h2C, 32'h0},
    '{1'b1, 8'h3C, 32'h0},        '{1'b1, 8'h2C, 32'hA5A50000},
    '{1'b0, 8'h1C, 32'h0},        '{1'b0, 8'h20, 32'h0},
    '{1'b0, 8'h10, 32'h5},        '{1'b1, 8'h10, 32'h5}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_irq(input int lim, output int k);
    k = 0;
    while (!irq && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, c0, c1;
    int k;
    rst_n = 1'b0; tick_en = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(8'h00, v); check("R1 id", v, 32'h13);
    rd(8'h14, v); check("R1 status", v, 32'h1);
    rd(8'h28, v); check("R1 counter", v, 32'h0);
    rd(8'h24, v); check("R1 control", v, 32'h0);
    rd(8'h18, v); check("R1 flags", v, 32'h0);
    rd(8'h34, v); check("R1 pending", v, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    check("R1 wake", {31'h0, wake}, 32'h0);

    // R2/R3 register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        rd(VEC[i].a, v);
        check($sformatf("R2/R3 table row %0d", i), v, VEC[i].d);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end
    check("R9 irq masked-off flags", {31'h0, irq}, 32'h0);

    // R5 negative preload with auto-reload
    tick_en = 1'b1;
    wr(8'h1C, 32'h2);
    wr(8'h2C, 32'h10);
    wr(8'h28, 32'hFFFFFFFB);
    wr(8'h24, 32'h3);
    wait_irq(50, k);
    check("R5 cycles to overflow", k, 32'd8);
    rd(8'h28, v); check("R5 reload value", v, 32'h10);
    rd(8'h18, v); check("R5 overflow flag", v, 32'h2);
    check("R9 wake off", {31'h0, wake}, 32'h0);
    wr(8'h20, 32'h2);
    check("R9 wake on", {31'h0, wake}, 32'h1);

    // R9 masking
    wr(8'h1C, 32'h0);
    check("R9 irq masked", {31'h0, irq}, 32'h0);
    rd(8'h18, v); check("R9 flag kept", v, 32'h2);

    // R8 write-one-to-clear
    wr(8'h18, 32'h5);
    rd(8'h18, v); check("R8 zero write keeps", v, 32'h2);
    wr(8'h18, 32'h2);
    rd(8'h18, v); check("R8 one clears", v, 32'h0);
    check("R8 wake dropped", {31'h0, wake}, 32'h0);

    // R4 rate unaffected by prescale bits
    wr(8'h24, 32'h3F);
    idle(4);
    rd(8'h28, c0);
    rd(8'h28, c1);
    check("R4 step per tick", c1, c0 + 32'd1);
    rd(8'h24, v); check("R4 control readback", v, 32'h3F);

    // R4 stopped holds
    wr(8'h24, 32'h0);
    idle(4);
    rd(8'h28, c0);
    idle(3);
    rd(8'h28, c1);
    check("R4 stopped holds", c1, c0);

    // R6 trigger
    wr(8'h2C, 32'h777);
    idle(4);
    wr(8'h30, 32'h1);
    rd(8'h34, v); check("R3 trigger pending bit", v, 32'h8);
    rd(8'h28, v); check("R6 not yet", v, c0);
    rd(8'h28, v); check("R6 not yet", v, c0);
    rd(8'h28, v); check("R6 loaded", v, 32'h777);

    // R3 override while pending
    wr(8'h2C, 32'h1);
    wr(8'h2C, 32'h2);
    rd(8'h2C, v); check("R3 override old", v, 32'h777);
    rd(8'h2C, v); check("R3 override old", v, 32'h777);
    rd(8'h2C, v); check("R3 first write suppressed", v, 32'h777);
    rd(8'h2C, v); check("R3 second write wins", v, 32'h2);

    // R5 one-shot
    wr(8'h1C, 32'h2);
    wr(8'h28, 32'hFFFFFFFE);
    wr(8'h24, 32'h1);
    wait_irq(50, k);
    check("R5 one-shot cycles", k, 32'd5);
    rd(8'h28, v); check("R5 one-shot zero", v, 32'h0);
    rd(8'h24, v); check("R5 run cleared", v, 32'h0);
    idle(3);
    rd(8'h28, v); check("R5 stays stopped", v, 32'h0);
    wr(8'h18, 32'h2);
    check("R8 irq cleared", {31'h0, irq}, 32'h0);

    // R7 compare
    wr(8'h1C, 32'h1);
    wr(8'h38, 32'h20);
    wr(8'h28, 32'h1C);
    wr(8'h24, 32'h41);
    wait_irq(50, k);
    check("R7 cycles to match", k, 32'd8);
    rd(8'h18, v); check("R7 match flag", v, 32'h1);
    wr(8'h24, 32'h0);
    idle(4);
    wr(8'h18, 32'h1);
    check("R8 match cleared irq", {31'h0, irq}, 32'h0);

    // R10 soft reset
    wr(8'h10, 32'h2);
    rd(8'h14, v); check("R10 status busy", v, 32'h0);
    rd(8'h14, v); check("R10 status done", v, 32'h1);
    rd(8'h2C, v); check("R10 reload cleared", v, 32'h0);
    rd(8'h1C, v); check("R10 enable cleared", v, 32'h0);
    rd(8'h38, v); check("R10 compare cleared", v, 32'h0);
    rd(8'h10, v); check("R10 config cleared", v, 32'h0);

    finish_run();
  end
endmodule